// File: doc/BRIEF.md
# Sobel Edge-Magnitude Engine

This block turns an 8-bit grayscale frame held in external memory into an edge-magnitude frame in a second external memory. A one-cycle `start` pulse launches the whole frame. The engine then walks the output frame in raster order. For each interior location it fetches the nine surrounding input pixels through a read-only port. It forms the horizontal and vertical Sobel gradients and writes `min(255, |Gx| + |Gy|)` through a write-only port. Border locations are written as zero, so that every output address is defined when the frame ends.

No line buffer or frame storage is kept inside. Each window is read again in full from memory, which keeps the area small but costs cycles. An interior pixel takes eleven cycles: nine reads, one cycle to take in the last read, and one write. A border pixel takes a single write cycle. `done` pulses once when the frame is complete.

Top module: `sobel_mm`

## Requirements
- R1: After reset, `done`, `rd_en` and `wr_en` are low, and they stay low until `start` is seen high.
- R2: A frame writes every output address from 0 to IMG_W*IMG_H-1 exactly once, in ascending order. The address of row r and column c is r*IMG_W + c.
- R3: An interior output is |Gx| + |Gy|. Gx uses the weights [-1 0 1; -2 0 2; -1 0 1] and Gy uses [-1 -2 -1; 0 0 0; 1 2 1], applied to the 3x3 window centred on the pixel, with the top row of each matrix for row r-1.
- R4: Whenever |Gx| + |Gy| is greater than 255, the written value is 255.
- R5: An output pixel in row 0, row IMG_H-1, column 0 or column IMG_W-1 is written as 0.
- R6: Each interior pixel issues exactly nine reads, in the order row r-1, r, r+1 and, within each row, column c-1, c, c+1. Border pixels issue no reads. Read data is taken one cycle after `rd_en`.
- R7: `done` is high for exactly one cycle, the cycle right after the write to the last address. No read or write happens in that cycle.
- R8: A `start` that arrives while a frame is in progress, or in the `done` cycle, is ignored. No second frame or extra write follows from it.
- R9: `rd_en` and `wr_en` are never high in the same cycle, and every address driven with its enable is below IMG_W*IMG_H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one frame (accepted only when idle) |
| done | output | 1 | One-cycle pulse at frame end |
| rd_en | output | 1 | Input memory read strobe |
| rd_addr | output | ADDR_W | Input memory address, ADDR_W = clog2(IMG_W*IMG_H) |
| rd_data | input | PIX_W | Input pixel, valid the cycle after `rd_en` |
| wr_en | output | 1 | Output memory write strobe |
| wr_addr | output | ADDR_W | Output memory address |
| wr_data | output | PIX_W | Output edge magnitude |

## Verification
A new `start` can land in the same cycle as the engine's own frame work: in the middle of a window fetch, in the cycle of the final write, or in the `done` cycle itself. The bench runs a small 6x5 frame and injects `start` at each of these three points on separate frames. It judges the result at the ports. The frame must still have exactly one write per address in order, exactly one `done`, and no further activity in the cycles that follow. Every written pixel is also compared with a value computed arithmetically in the bench from the loaded image, over ramp, split, checkerboard and pseudo-random images.

// File: rtl/sobel_mm.sv
module sobel_mm #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  parameter int PIX_W = 8,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data
);

  localparam int CW    = $clog2(IMG_W);
  localparam int RW    = $clog2(IMG_H);
  localparam int ACC_W = PIX_W + 4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DRAIN, S_WRITE, S_FIN} state_t;

  state_t                   st;
  logic [RW-1:0]            row, nrow;
  logic [CW-1:0]            col, ncol;
  logic [1:0]               kr, kc, kr_d, kc_d;
  logic                     tap_v;
  logic signed [ACC_W-1:0]  gx, gy;
  logic signed [ACC_W-1:0]  px, wx, wy;
  logic [ACC_W-1:0]         ax, ay, mag;
  logic [ADDR_W-1:0]        lin;
  logic                     last_col, last_row, border, nborder;

  assign last_col = (col == CW'(IMG_W - 1));
  assign last_row = (row == RW'(IMG_H - 1));
  assign border   = (row == '0) || last_row || (col == '0) || last_col;
  assign ncol     = last_col ? '0 : col + 1'b1;
  assign nrow     = last_col ? row + 1'b1 : row;
  assign nborder  = (nrow == '0) || (nrow == RW'(IMG_H - 1)) ||
                    (ncol == '0) || (ncol == CW'(IMG_W - 1));

  assign lin     = ADDR_W'(row) * ADDR_W'(IMG_W) + ADDR_W'(col);
  assign rd_en   = (st == S_FETCH);
  assign rd_addr = lin + ADDR_W'(kr) * ADDR_W'(IMG_W) + ADDR_W'(kc) - ADDR_W'(IMG_W + 1);

  assign px = $signed({{(ACC_W - PIX_W){1'b0}}, rd_data});
  assign wx = (kr_d == 2'd1) ? (px <<< 1) : px;
  assign wy = (kc_d == 2'd1) ? (px <<< 1) : px;

  assign ax  = gx[ACC_W-1] ? unsigned'(-gx) : unsigned'(gx);
  assign ay  = gy[ACC_W-1] ? unsigned'(-gy) : unsigned'(gy);
  assign mag = ax + ay;

  assign wr_en   = (st == S_WRITE);
  assign wr_addr = lin;
  assign wr_data = border ? '0 :
                   (mag > ACC_W'((1 << PIX_W) - 1)) ? '1 : mag[PIX_W-1:0];
  assign done    = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      row   <= '0;
      col   <= '0;
      kr    <= '0;
      kc    <= '0;
      kr_d  <= '0;
      kc_d  <= '0;
      tap_v <= 1'b0;
      gx    <= '0;
      gy    <= '0;
    end else begin
      tap_v <= (st == S_FETCH);
      kr_d  <= kr;
      kc_d  <= kc;
      if (tap_v) begin
        if (kc_d == 2'd0) gx <= gx - wx;
        else if (kc_d == 2'd2) gx <= gx + wx;
        if (kr_d == 2'd0) gy <= gy - wy;
        else if (kr_d == 2'd2) gy <= gy + wy;
      end
      case (st)
        S_IDLE: if (start) begin
          row <= '0;
          col <= '0;
          gx  <= '0;
          gy  <= '0;
          st  <= S_WRITE;
        end
        S_FETCH: begin
          if (kc == 2'd2) begin
            kc <= '0;
            if (kr == 2'd2) begin
              kr <= '0;
              st <= S_DRAIN;
            end else begin
              kr <= kr + 1'b1;
            end
          end else begin
            kc <= kc + 1'b1;
          end
        end
        S_DRAIN: st <= S_WRITE;
        S_WRITE: begin
          if (last_row && last_col) begin
            st <= S_FIN;
          end else begin
            row <= nrow;
            col <= ncol;
            gx  <= '0;
            gy  <= '0;
            st  <= nborder ? S_WRITE : S_FETCH;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sobel_mm_chk.sv
module sobel_mm_chk #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  parameter int PIX_W = 8,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PIX_W-1:0]  wr_data
);

  localparam int NPIX = IMG_W * IMG_H;

  logic wb;
  always_comb begin
    wb = ((int'(wr_addr) % IMG_W) == 0) || ((int'(wr_addr) % IMG_W) == IMG_W - 1) ||
         ((int'(wr_addr) / IMG_W) == 0) || ((int'(wr_addr) / IMG_W) == IMG_H - 1);
  end

  p_rw_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  p_rd_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_addr) < NPIX));
  p_wr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NPIX));
  p_border_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wb) |-> (wr_data == '0));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && (int'($past(wr_addr)) == NPIX - 1)));
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_en && !wr_en));

endmodule

bind sobel_mm sobel_mm_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sobel_mm_tb.sv
module sobel_mm_tb;
  localparam int CLK_P  = 10;
  localparam int W      = 6;
  localparam int H      = 5;
  localparam int N      = W * H;
  localparam int AW     = $clog2(N);
  localparam int NINT   = (W - 2) * (H - 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;

  int img [N];
  int outbuf [N];
  int wcount [N];
  int vectors = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  sobel_mm #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (rd_en) rd_data <= (int'(rd_addr) < N) ? 8'(img[rd_addr]) : 8'hxx;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic bit is_border(input int r, input int c);
    return (r == 0) || (r == H - 1) || (c == 0) || (c == W - 1);
  endfunction

  function automatic int raw_mag(input int r, input int c);
    int gx = 0, gy = 0;
    for (int kr = 0; kr < 3; kr++)
      for (int kc = 0; kc < 3; kc++) begin
        int p = img[(r + kr - 1) * W + c + kc - 1];
        int wx = (kr == 1) ? 2 : 1;
        int wy = (kc == 1) ? 2 : 1;
        if (kc == 0) gx -= wx * p;
        if (kc == 2) gx += wx * p;
        if (kr == 0) gy -= wy * p;
        if (kr == 2) gy += wy * p;
      end
    return (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
  endfunction

  function automatic int exp_rd(input int n);
    int p = n / 9, t = n % 9;
    if (p >= NINT) return -1;
    return (1 + p / (W - 2) + t / 3 - 1) * W + 1 + p % (W - 2) + t % 3 - 1;
  endfunction

  // mode 0: plain, 1: start mid-fetch, 2: start on last write, 3: start in done cycle
  task automatic run_frame(input int mode, input string name);
    int wr_n = 0, rd_n = 0, done_n = 0, cyc = 0, post = 0;
    int bad_order = 0, bad_rd = 0, bad_done = 0, exp_next = 0, prev_addr = -1;
    bit prev_wr = 0, seen = 0;
    for (int i = 0; i < N; i++) begin
      wcount[i] = 0;
      outbuf[i] = -1;
    end
    @(negedge clk) start = 1'b1;
    while (post < 8 && cyc < 4000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (wr_en) begin
        if (int'(wr_addr) < N) begin
          outbuf[wr_addr] = int'(wr_data);
          wcount[wr_addr]++;
        end
        if (int'(wr_addr) != exp_next) bad_order++;
        exp_next++;
        wr_n++;
      end
      if (rd_en) begin
        if (int'(rd_addr) != exp_rd(rd_n)) bad_rd++;
        rd_n++;
      end
      if (done) begin
        done_n++;
        if (!(prev_wr && prev_addr == N - 1)) bad_done++;
        seen = 1;
      end
      if (seen) post++;
      if (mode == 1 && cyc == 15) start = 1'b1;
      if (mode == 2 && wr_en && int'(wr_addr) == N - 1) start = 1'b1;
      if (mode == 3 && done) start = 1'b1;
      prev_wr = wr_en;
      prev_addr = int'(wr_addr);
    end
    chk(seen, "R7", {name, " done seen"}, int'(seen), 1);
    chk(done_n == 1, mode == 0 ? "R7" : "R8", {name, " done count"}, done_n, 1);
    chk(bad_done == 0, "R7", {name, " done not right after last write"}, bad_done, 0);
    chk(wr_n == N, mode == 0 ? "R2" : "R8", {name, " write count"}, wr_n, N);
    chk(bad_order == 0, "R2", {name, " write order errors"}, bad_order, 0);
    chk(rd_n == 9 * NINT, "R6", {name, " read count"}, rd_n, 9 * NINT);
    chk(bad_rd == 0, "R6", {name, " read address errors"}, bad_rd, 0);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int a = r * W + c;
        chk(wcount[a] == 1, "R2", $sformatf("%s writes to addr %0d", name, a), wcount[a], 1);
        if (is_border(r, c)) begin
          chk(outbuf[a] == 0, "R5", $sformatf("%s border px %0d", name, a), outbuf[a], 0);
        end else begin
          int m = raw_mag(r, c);
          if (m > 255)
            chk(outbuf[a] == 255, "R4", $sformatf("%s saturated px %0d", name, a), outbuf[a], 255);
          else
            chk(outbuf[a] == m, "R3", $sformatf("%s px %0d", name, a), outbuf[a], m);
        end
      end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL R2 watchdog expired: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seed = 32'h1ACE;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(!done && !rd_en && !wr_en, "R1", "outputs during reset", int'({done, rd_en, wr_en}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!done && !rd_en && !wr_en, "R1", "idle before start", int'({done, rd_en, wr_en}), 0);
    end

    for (int i = 0; i < N; i++) img[i] = ((i / W) * 20 + (i % W) * 7) & 255;
    run_frame(0, "ramp");

    for (int i = 0; i < N; i++) img[i] = ((i % W) >= W / 2) ? 255 : 0;
    run_frame(0, "split");

    for (int i = 0; i < N; i++) img[i] = (((i / W) + (i % W)) % 2 == 1) ? 255 : 0;
    run_frame(1, "checker_midstart");

    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < N; i++) begin
        seed = seed * 1103515245 + 12345;
        img[i] = (seed >>> 16) & 255;
      end
      run_frame(k + 1, $sformatf("random%0d", k));
    end

    for (int i = 0; i < N; i++) img[i] = 200;
    run_frame(0, "flat");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule